// File: doc/BRIEF.md
# Clock Crosspoint with Glitch-Free Post Dividers

This block takes four source clocks (one reference and three synthesized clocks) and distributes them to three output channels. Every channel picks any one of the four sources, may use that source in inverted phase, and divides it by a 7-bit post-divide value. The first two channels each see two divide values and a shared frequency-select input chooses between them. The third channel has only one value that counts.

The source clocks arrive as ordinary digital levels. They are oversampled by the fast system clock `clk`, and every channel advances its divider on the detected source edges. The divider counts source half-periods, so the output is high for exactly half of its period for every divide value, odd values included. A new divide value is loaded only when the current output period ends, so changing frequency select never gives a shortened phase. Each channel also has an enable. While the enable is low the channel's output-enable flag is low (its pad would be three-stated), the clock output is held low and the divider waits idle. While the channel is disabled, its source selection and inversion are taken from the inputs.

Top module: `clkx_crosspoint`

## Requirements
- R1: A channel's 2-bit source code `sel_i[2c+1:2c]` routes source `src_i[code]` to channel c: code 0 is the reference, and codes 1 to 3 are synthesized clocks 1 to 3. Any code may be used on any channel.
- R2: With an effective divide value N, the output period is 2N source half-periods and the output is high for exactly N of them, starting at a source rising edge. A source level change sampled at one `clk` rising edge shows up on `clk_o` at the following `clk` rising edge.
- R3: With N = 1 the output follows the source: it is high for one source half-period and low for the next.
- R4: A divide value of 0 acts as N = 1.
- R5: Channels 0 and 1 use their `div_hi_i` slice when the synchronized frequency select is 1 and their `div_lo_i` slice when it is 0. `fs_i` passes through a two-stage synchronizer.
- R6: Channel 2 always uses its `div_lo_i` slice. It ignores `fs_i` and its `div_hi_i` slice.
- R7: A new divide value is loaded only at the end of an output period. The high and low phases already under way keep their old length.
- R8: With `inv_i[c]` set, channel c divides the inverted source, so its high phase starts at a source falling edge. Two channels on the same source with N = 1, one of them inverted, give complementary outputs.
- R9: When `en_i[c]` is low, `oe_o[c]` and `clk_o[c]` are low after the next `clk` edge. After the enable returns, the first output high phase starts at the first rising edge of the selected source.
- R10: `sel_i` and `inv_i` for a channel are captured only while that channel is disabled. Changes made while it is enabled have no effect.
- R11: Synchronous reset drives every `oe_o` and `clk_o` bit low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the sources |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 4 | Source clocks: bit 0 reference, bits 1-3 synthesized clocks |
| en_i | input | 3 | Per-channel enable |
| inv_i | input | 3 | Per-channel inverted-phase select |
| sel_i | input | 6 | Per-channel 2-bit source code |
| fs_i | input | 1 | Frequency select, asynchronous |
| div_lo_i | input | 21 | Per-channel 7-bit divide value used when the select is 0 |
| div_hi_i | input | 21 | Per-channel 7-bit divide value used when the select is 1 (channels 0 and 1) |
| clk_o | output | 3 | Divided clock per channel |
| oe_o | output | 3 | Output-enable flag per channel |

## Verification
The hardest case to reach is a divide value that changes while an output period is in progress. The bench waits at the ports for a rising output edge and changes the value in that same cycle. It then measures the remaining high and low phases, which must keep the old length, and after that a full period at the new value. Frequency-select changes are checked the same way, through the synchronizer, and a cycle-by-cycle behavioural model catches any stray edge in between. Inverted-phase operation is shown by running two channels on one source and requiring their outputs to stay complementary.

// File: rtl/clkx_pkg.sv
package clkx_pkg;

    // Edges seen on one channel's sampled source level
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    // Divider activity
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Map an illegal zero divide value onto one
    function automatic logic [31:0] legal_div(input logic [31:0] v);
        return (v == 32'd0) ? 32'd1 : v;
    endfunction

endpackage

// File: rtl/clkx_src_tap.sv
module clkx_src_tap
    import clkx_pkg::*;
#(
    parameter int NSRC = 4,
    parameter int SELW = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [NSRC-1:0] src,
    input  logic [SELW-1:0] sel,
    input  logic            inv,
    output edge_t           edg
);

    logic [SELW-1:0] sel_q;
    logic            inv_q;
    logic            lvl;
    logic            lvl_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            inv_q <= 1'b0;
            lvl   <= 1'b0;
            lvl_p <= 1'b0;
        end else begin
            if (!en) begin
                sel_q <= sel;
                inv_q <= inv;
            end
            lvl   <= src[sel_q] ^ inv_q;
            lvl_p <= lvl;
        end
    end

    always_comb begin
        edg.rise = lvl & ~lvl_p;
        edg.fall = ~lvl & lvl_p;
    end

    AST_ROUTE_HOLD: assert property (@(posedge clk) disable iff (rst)
        en |=> ($stable(sel_q) && $stable(inv_q))); // R10

endmodule

// File: rtl/clkx_div_pick.sv
module clkx_div_pick
    import clkx_pkg::*;
#(
    parameter int DW     = 7,
    parameter bit HAS_FS = 1'b1
) (
    input  logic          fs,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] hi,
    output logic [DW-1:0] nval
);

    logic          use_hi;
    logic [DW-1:0] raw;
    logic [31:0]   fixed;

    always_comb begin
        use_hi = HAS_FS ? fs : 1'b0;
        raw    = use_hi ? hi : lo;
        fixed  = legal_div(32'(raw));
        nval   = fixed[DW-1:0];
    end

endmodule

// File: rtl/clkx_post_div.sv
module clkx_post_div
    import clkx_pkg::*;
#(
    parameter int DW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  edge_t         edg,
    input  logic [DW-1:0] nval,
    output logic          clk_o,
    output logic          oe_o
);

    localparam int HW = DW + 1;

    run_state_e    st;
    logic [HW-1:0] h;
    logic [DW-1:0] n;
    logic [HW-1:0] last;
    logic [HW-1:0] h_inc;
    logic          any_edge;

    always_comb begin
        last     = {n, 1'b0} - {{DW{1'b0}}, 1'b1};
        h_inc    = h + {{DW{1'b0}}, 1'b1};
        any_edge = edg.rise | edg.fall;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            h     <= '0;
            n     <= {{(DW-1){1'b0}}, 1'b1};
            clk_o <= 1'b0;
            oe_o  <= 1'b0;
        end else begin
            oe_o <= en;
            if (!en) begin
                st    <= ST_IDLE;
                h     <= '0;
                clk_o <= 1'b0;
            end else if (st == ST_IDLE) begin
                if (edg.rise) begin
                    st    <= ST_RUN;
                    h     <= '0;
                    n     <= nval;
                    clk_o <= 1'b1;
                end
            end else if (any_edge) begin
                if (h == last) begin
                    h     <= '0;
                    n     <= nval;
                    clk_o <= 1'b1;
                end else begin
                    h     <= h_inc;
                    clk_o <= (h_inc < {1'b0, n});
                end
            end
        end
    end

    AST_NO_STRAY_EDGE: assert property (@(posedge clk) disable iff (rst)
        (en && st == ST_RUN && !any_edge) |=> $stable(clk_o)); // R7

    AST_LOAD_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (en && st == ST_RUN && any_edge && h != last) |=> (n == $past(n))); // R7

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!oe_o && !clk_o)); // R9

    AST_NONZERO_DIV: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN) |-> (n != '0)); // R4

    AST_IDLE_WAITS_RISE: assert property (@(posedge clk) disable iff (rst)
        (en && st == ST_IDLE && !edg.rise) |=> !clk_o); // R9

endmodule

// File: rtl/clkx_crosspoint.sv
module clkx_crosspoint
    import clkx_pkg::*;
#(
    parameter int NSRC = 4,
    parameter int NCH  = 3,
    parameter int DW   = 7,
    parameter int NFS  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NSRC-1:0]     src_i,
    input  logic [NCH-1:0]      en_i,
    input  logic [NCH-1:0]      inv_i,
    input  logic [NCH*2-1:0]    sel_i,
    input  logic                fs_i,
    input  logic [NCH*DW-1:0]   div_lo_i,
    input  logic [NCH*DW-1:0]   div_hi_i,
    output logic [NCH-1:0]      clk_o,
    output logic [NCH-1:0]      oe_o
);

    localparam int SELW = $clog2(NSRC);

    logic fs_s1;
    logic fs_s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_s1 <= 1'b0;
            fs_s2 <= 1'b0;
        end else begin
            fs_s1 <= fs_i;
            fs_s2 <= fs_s1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (oe_o == '0 && clk_o == '0)); // R11

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        edge_t         edg;
        logic [DW-1:0] nval;

        clkx_src_tap #(.NSRC(NSRC), .SELW(SELW)) tap_i (
            .clk (clk),
            .rst (rst),
            .en  (en_i[c]),
            .src (src_i),
            .sel (sel_i[c*2 +: SELW]),
            .inv (inv_i[c]),
            .edg (edg)
        );

        clkx_div_pick #(.DW(DW), .HAS_FS(c < NFS)) pick_i (
            .fs   (fs_s2),
            .lo   (div_lo_i[c*DW +: DW]),
            .hi   (div_hi_i[c*DW +: DW]),
            .nval (nval)
        );

        clkx_post_div #(.DW(DW)) div_i (
            .clk   (clk),
            .rst   (rst),
            .en    (en_i[c]),
            .edg   (edg),
            .nval  (nval),
            .clk_o (clk_o[c]),
            .oe_o  (oe_o[c])
        );
    end

endmodule

// File: tb/clkx_crosspoint_tb.sv
module clkx_crosspoint_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;
    localparam int DW  = 7;

    logic              clk = 1'b0;
    logic              rst;
    logic [3:0]        src_i;
    logic [NCH-1:0]    en_i;
    logic [NCH-1:0]    inv_i;
    logic [NCH*2-1:0]  sel_i;
    logic              fs_i;
    logic [NCH*DW-1:0] div_lo_i;
    logic [NCH*DW-1:0] div_hi_i;
    logic [NCH-1:0]    clk_o;
    logic [NCH-1:0]    oe_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int tick   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkx_crosspoint dut_i (
        .clk(clk), .rst(rst), .src_i(src_i), .en_i(en_i), .inv_i(inv_i),
        .sel_i(sel_i), .fs_i(fs_i), .div_lo_i(div_lo_i), .div_hi_i(div_hi_i),
        .clk_o(clk_o), .oe_o(oe_o)
    );

    // Sources: reference half 3, clock1 half 2, clock2 half 5, clock3 half 1 (in clk cycles)
    always @(negedge clk) begin
        src_i[0] <= ((tick / 3) % 2) == 1;
        src_i[1] <= ((tick / 2) % 2) == 1;
        src_i[2] <= ((tick / 5) % 2) == 1;
        src_i[3] <= (tick % 2) == 1;
        tick <= tick + 1;
    end

    // Behavioural reference model, stepped on every clk rising edge
    int m_fs1, m_fs2;
    int m_sel[NCH], m_inv[NCH], m_lv[NCH], m_lp[NCH];
    int m_run[NCH], m_h[NCH], m_n[NCH], m_out[NCH], m_oe[NCH];
    int shown = 0;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            m_fs1 = 0; m_fs2 = 0;
            for (int c = 0; c < NCH; c++) begin
                m_sel[c] = 0; m_inv[c] = 0; m_lv[c] = 0; m_lp[c] = 0;
                m_run[c] = 0; m_h[c] = 0; m_n[c] = 1; m_out[c] = 0; m_oe[c] = 0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                int rise, fall, want, lvl_new;
                rise = (m_lv[c] == 1 && m_lp[c] == 0) ? 1 : 0;
                fall = (m_lv[c] == 0 && m_lp[c] == 1) ? 1 : 0;
                want = (c < 2 && m_fs2 == 1) ? int'(div_hi_i[c*DW +: DW])
                                             : int'(div_lo_i[c*DW +: DW]);
                if (want == 0) want = 1;
                if (!en_i[c]) begin
                    m_run[c] = 0; m_h[c] = 0; m_out[c] = 0;
                end else if (m_run[c] == 0) begin
                    if (rise == 1) begin
                        m_run[c] = 1; m_h[c] = 0; m_n[c] = want; m_out[c] = 1;
                    end
                end else if (rise == 1 || fall == 1) begin
                    if (m_h[c] == 2 * m_n[c] - 1) begin
                        m_h[c] = 0; m_n[c] = want; m_out[c] = 1;
                    end else begin
                        m_h[c] = m_h[c] + 1;
                        m_out[c] = (m_h[c] < m_n[c]) ? 1 : 0;
                    end
                end
                m_oe[c] = en_i[c] ? 1 : 0;
                lvl_new = (src_i[m_sel[c]] ^ (m_inv[c] != 0)) ? 1 : 0;
                m_lp[c] = m_lv[c];
                m_lv[c] = lvl_new;
                if (!en_i[c]) begin
                    m_sel[c] = int'(sel_i[c*2 +: 2]);
                    m_inv[c] = inv_i[c] ? 1 : 0;
                end
            end
            m_fs2 = m_fs1;
            m_fs1 = fs_i ? 1 : 0;
        end
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Cycle-by-cycle comparison against the model (R2, R7, R9)
    always @(negedge clk) begin
        if (!rst) begin
            for (int c = 0; c < NCH; c++) begin
                checks = checks + 1;
                if (int'(clk_o[c]) != m_out[c] || int'(oe_o[c]) != m_oe[c]) begin
                    errors = errors + 1;
                    if (shown < 10)
                        $display("FAIL R2/R7 model ch%0d clk_o=%b oe_o=%b expected %0d %0d",
                                 c, clk_o[c], oe_o[c], m_out[c], m_oe[c]);
                    shown = shown + 1;
                end
            end
        end
    end

    task automatic chk(input int got, input int exp, input string tag);
        checks = checks + 1;
        if (got != exp) begin
            errors = errors + 1;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic meas(input int c, output int hi, output int lo);
        while (clk_o[c] !== 1'b0) @(negedge clk);
        while (clk_o[c] !== 1'b1) @(negedge clk);
        hi = 0;
        while (clk_o[c] === 1'b1) begin hi++; @(negedge clk); end
        lo = 0;
        while (clk_o[c] === 1'b0) begin lo++; @(negedge clk); end
    endtask

    task automatic meas_chk(input int c, input int skip, input int ehi, input int elo,
                            input string tag);
        int hi, lo;
        for (int k = 0; k < skip; k++) meas(c, hi, lo);
        meas(c, hi, lo);
        chk(hi, ehi, {tag, " high phase"});
        chk(lo, elo, {tag, " low phase"});
    endtask

    task automatic set_div(input int c, input int lo, input int hi);
        div_lo_i[c*DW +: DW] = 7'(lo);
        div_hi_i[c*DW +: DW] = 7'(hi);
    endtask

    initial begin
        int hi, lo, bad;
        rst = 1'b1; en_i = '0; inv_i = '0; fs_i = 1'b0;
        sel_i = '0; div_lo_i = '0; div_hi_i = '0; src_i = '0;
        repeat (3) @(negedge clk);
        chk(int'(oe_o), 0, "R11 reset oe_o");
        chk(int'(clk_o), 0, "R11 reset clk_o");
        rst = 1'b0;

        // Routing and divide values, fs low
        sel_i = {2'd0, 2'd2, 2'd1};
        set_div(0, 3, 5); set_div(1, 2, 1); set_div(2, 1, 9);
        repeat (3) @(negedge clk);
        en_i = 3'b111;
        meas_chk(0, 1, 6, 6, "R1 R2 ch0 clock1 N=3");
        meas_chk(1, 1, 10, 10, "R1 R2 ch1 clock2 N=2");
        meas_chk(2, 1, 3, 3, "R1 R3 ch2 reference N=1");

        // Frequency select high
        fs_i = 1'b1;
        meas_chk(0, 2, 10, 10, "R5 ch0 alternate value 5");
        meas_chk(1, 2, 5, 5, "R5 ch1 alternate value 1");
        meas_chk(2, 1, 3, 3, "R6 ch2 ignores fs");

        // Zero divide value
        fs_i = 1'b0;
        set_div(0, 0, 5);
        meas_chk(0, 2, 2, 2, "R4 ch0 zero acts as one");

        // Retarget in the middle of a period
        en_i[0] = 1'b0;
        sel_i[1:0] = 2'd3;
        set_div(0, 4, 5);
        repeat (3) @(negedge clk);
        en_i[0] = 1'b1;
        meas_chk(0, 0, 4, 4, "R9 R1 ch0 restart on clock3 N=4");
        while (clk_o[0] !== 1'b0) @(negedge clk);
        while (clk_o[0] !== 1'b1) @(negedge clk);
        set_div(0, 2, 5);
        hi = 0; while (clk_o[0] === 1'b1) begin hi++; @(negedge clk); end
        lo = 0; while (clk_o[0] === 1'b0) begin lo++; @(negedge clk); end
        chk(hi, 4, "R7 high phase in progress keeps old length");
        chk(lo, 4, "R7 low phase in progress keeps old length");
        meas_chk(0, 0, 2, 2, "R7 next period uses new value");

        // Inverted phase on a shared source
        en_i[1:0] = 2'b00;
        sel_i[3:0] = {2'd1, 2'd1};
        set_div(0, 1, 1); set_div(1, 1, 1);
        inv_i[1] = 1'b1;
        repeat (3) @(negedge clk);
        en_i[1:0] = 2'b11;
        repeat (12) @(negedge clk);
        bad = 0;
        for (int k = 0; k < 16; k++) begin
            if (clk_o[1] === clk_o[0]) bad++;
            @(negedge clk);
        end
        chk(bad, 0, "R8 inverted channel complementary cycles");

        // Route change while enabled is ignored
        sel_i[1:0] = 2'd3;
        repeat (3) @(negedge clk);
        meas_chk(0, 1, 2, 2, "R10 selection change while enabled ignored");

        // Disable, then re-enable picks the new route
        while (clk_o[0] !== 1'b1) @(negedge clk);
        en_i[0] = 1'b0;
        @(negedge clk);
        chk(int'(oe_o[0]), 0, "R9 oe_o low one cycle after disable");
        chk(int'(clk_o[0]), 0, "R9 clk_o low one cycle after disable");
        chk(int'(oe_o[1]), 1, "R9 other channel stays enabled");
        en_i[0] = 1'b1;
        meas_chk(0, 1, 1, 1, "R10 route captured while disabled");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule